// File: doc/BRIEF.md
# UART Modem Control with Internal Loopback

This block holds the modem-control byte of a serial port and turns it into pin levels. Two bits assert the active-low request-to-send and data-terminal-ready outputs. Two general-purpose bits drive their own active-low outputs, and the second of these also acts as the master gate on the port's interrupt line. Software writes the byte through a simple write strobe, and the stored value is always visible on a read-data bus. The three upper bits are unused and read as zero.

A loop bit switches the port into self-test. In that mode the four control outputs are parked at their inactive high level and the serial output pin idles at 1. The transmitter's bit stream goes straight to the receiver input. The four control bits are reflected onto the modem-status lines that the status logic samples, in place of the external inputs. Outside loopback the status lines are the inverted external active-low inputs, and the serial lines pass through unchanged.

Top module: `mcr_loopback`

## Requirements
- R1: After an asynchronous reset, the read data is 0 and the four control pins (rts_no, dtr_no, out1_no, out2_no) are all 1.
- R2: A write stores bits 4:0 of wr_data_i, and these appear on rd_data_o from the next clock edge. Bits 7:5 always read 0. Without a write, the stored value holds.
- R3: Outside loopback, control bit 1 drives rts_no: a 1 gives 0 and a 0 gives 1.
- R4: Outside loopback, control bit 0 drives dtr_no: a 1 gives 0 and a 0 gives 1.
- R5: Outside loopback, control bit 2 drives out1_no low when set, and control bit 3 drives out2_no low when set.
- R6: irq_o equals irq_raw_i AND control bit 3, in both normal and loopback mode.
- R7: When control bit 4 (loop) is set, rts_no, dtr_no, out1_no and out2_no are all 1, whatever the other bits hold.
- R8: In loopback, sout_o is 1 and rx_bit_o follows tx_bit_i. Outside loopback, sout_o follows tx_bit_i and rx_bit_o follows sin_i.
- R9: msr_stat_o is ordered {dcd, ri, dsr, cts}. Outside loopback it is the inverse of {dcd_ni, ri_ni, dsr_ni, cts_ni}. In loopback it is {bit 3, bit 2, bit 0, bit 1}, so OUT2 maps to dcd, OUT1 to ri, DTR to dsr and RTS to cts, and the external inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Stored control byte, upper bits zero |
| cts_ni | input | 1 | External clear-to-send, active low |
| dsr_ni | input | 1 | External data-set-ready, active low |
| ri_ni | input | 1 | External ring indicator, active low |
| dcd_ni | input | 1 | External carrier detect, active low |
| msr_stat_o | output | 4 | Status lines to the status logic {dcd, ri, dsr, cts}, active high |
| rts_no | output | 1 | Request-to-send pin, active low |
| dtr_no | output | 1 | Data-terminal-ready pin, active low |
| out1_no | output | 1 | General output 1, active low |
| out2_no | output | 1 | General output 2, active low |
| tx_bit_i | input | 1 | Serial bit from the transmitter |
| sout_o | output | 1 | Serial output pin |
| sin_i | input | 1 | Serial input pin |
| rx_bit_o | output | 1 | Serial bit to the receiver |
| irq_raw_i | input | 1 | Interrupt request before the master gate |
| irq_o | output | 1 | Gated interrupt |

## Verification
Every one of the 256 write values is applied. Under each one, all 128 combinations of the four status inputs, the two serial lines and the raw interrupt are swept. The values with the loop bit clear and set separate the pin-parking and remapping paths from normal pass-through. Because the status inputs are swept independently of each other, any swap in the loopback mapping of RTS/DTR onto cts/dsr shows up, and so does any external input that leaks through during loopback. The values with bit 3 clear and set, combined with both levels of the raw interrupt, separate the interrupt gate from the loop bit. The nonzero upper bits of the write data show whether the reserved field stays zero.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned BIT_DTR  = 0;
  localparam int unsigned BIT_RTS  = 1;
  localparam int unsigned BIT_OUT1 = 2;
  localparam int unsigned BIT_OUT2 = 3;
  localparam int unsigned BIT_LOOP = 4;
  localparam int unsigned USED_W   = 5;
  localparam int unsigned N_CTL    = 4;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } ctrl_t;
endpackage

// File: rtl/mcr_ctrl_reg.sv
module mcr_ctrl_reg
  import mcr_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int unsigned RSV_W = REG_W - USED_W;

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= ctrl_t'(wr_data_i[USED_W-1:0]);
  end

  assign ctrl_o    = ctrl_q;
  assign rd_data_o = {{RSV_W{1'b0}}, ctrl_q};
endmodule

// File: rtl/mcr_pin_drv.sv
module mcr_pin_drv #(
  parameter int unsigned N_OUT = 4
) (
  input  logic [N_OUT-1:0] act_i,
  input  logic             park_i,
  output logic [N_OUT-1:0] pin_no
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_pin
    // parked pins sit at their inactive (high) level
    assign pin_no[i] = ~(act_i[i] & ~park_i);
  end
endmodule

// File: rtl/mcr_loop_route.sv
module mcr_loop_route
  import mcr_pkg::*;
(
  input  logic             loop_i,
  input  ctrl_t            ctrl_i,
  input  logic [N_CTL-1:0] ext_stat_ni,  // {dcd, ri, dsr, cts}, active low
  input  logic             tx_bit_i,
  input  logic             sin_i,
  output logic [N_CTL-1:0] stat_o,       // {dcd, ri, dsr, cts}, active high
  output logic             sout_o,
  output logic             rx_bit_o
);
  logic [N_CTL-1:0] loop_stat;

  assign loop_stat = {ctrl_i.out2, ctrl_i.out1, ctrl_i.dtr, ctrl_i.rts};

  always_comb begin
    if (loop_i) begin
      stat_o   = loop_stat;
      sout_o   = 1'b1;
      rx_bit_o = tx_bit_i;
    end else begin
      stat_o   = ~ext_stat_ni;
      sout_o   = tx_bit_i;
      rx_bit_o = sin_i;
    end
  end
endmodule

// File: rtl/mcr_loopback.sv
module mcr_loopback
  import mcr_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             cts_ni,
  input  logic             dsr_ni,
  input  logic             ri_ni,
  input  logic             dcd_ni,
  output logic [N_CTL-1:0] msr_stat_o,
  output logic             rts_no,
  output logic             dtr_no,
  output logic             out1_no,
  output logic             out2_no,
  input  logic             tx_bit_i,
  output logic             sout_o,
  input  logic             sin_i,
  output logic             rx_bit_o,
  input  logic             irq_raw_i,
  output logic             irq_o
);
  ctrl_t            ctrl;
  logic [N_CTL-1:0] pins_n;

  mcr_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .rd_data_o (rd_data_o)
  );

  mcr_pin_drv #(.N_OUT(N_CTL)) u_pins (
    .act_i  ({ctrl.out2, ctrl.out1, ctrl.rts, ctrl.dtr}),
    .park_i (ctrl.loop),
    .pin_no (pins_n)
  );

  assign {out2_no, out1_no, rts_no, dtr_no} = pins_n;

  mcr_loop_route u_route (
    .loop_i      (ctrl.loop),
    .ctrl_i      (ctrl),
    .ext_stat_ni ({dcd_ni, ri_ni, dsr_ni, cts_ni}),
    .tx_bit_i    (tx_bit_i),
    .sin_i       (sin_i),
    .stat_o      (msr_stat_o),
    .sout_o      (sout_o),
    .rx_bit_o    (rx_bit_o)
  );

  // OUT2 is the master interrupt enable in every mode
  assign irq_o = irq_raw_i & ctrl.out2;
endmodule

// File: rtl/mcr_loopback_chk.sv
module mcr_loopback_chk #(
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic [3:0]       msr_stat_o,
  input logic             rts_no,
  input logic             dtr_no,
  input logic             out1_no,
  input logic             out2_no,
  input logic             tx_bit_i,
  input logic             sout_o,
  input logic             rx_bit_o,
  input logic             irq_o
);
  a_r2_wr_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[4:0] == $past(wr_data_i[4:0]));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
  a_r6_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[3] |-> !irq_o);
  a_r7_loop_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[4] |-> (rts_no && dtr_no && out1_no && out2_no));
  a_r8_loop_serial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[4] |-> (sout_o && rx_bit_o == tx_bit_i));
  a_r9_loop_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[4] |-> msr_stat_o == {rd_data_o[3], rd_data_o[2], rd_data_o[0], rd_data_o[1]});
endmodule

bind mcr_loopback mcr_loopback_chk #(.REG_W(REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .msr_stat_o (msr_stat_o),
  .rts_no     (rts_no),
  .dtr_no     (dtr_no),
  .out1_no    (out1_no),
  .out2_no    (out2_no),
  .tx_bit_i   (tx_bit_i),
  .sout_o     (sout_o),
  .rx_bit_o   (rx_bit_o),
  .irq_o      (irq_o)
);

// File: tb/mcr_loopback_bench.sv
`timescale 1ns/1ps
module mcr_loopback_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       cts_ni = 1'b1, dsr_ni = 1'b1, ri_ni = 1'b1, dcd_ni = 1'b1;
  logic [3:0] msr_stat_o;
  logic       rts_no, dtr_no, out1_no, out2_no;
  logic       tx_bit_i = 1'b1, sout_o, sin_i = 1'b1, rx_bit_o;
  logic       irq_raw_i = 1'b0, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mcr_loopback u_mcr_loopback (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .cts_ni(cts_ni), .dsr_ni(dsr_ni), .ri_ni(ri_ni),
    .dcd_ni(dcd_ni), .msr_stat_o(msr_stat_o), .rts_no(rts_no), .dtr_no(dtr_no),
    .out1_no(out1_no), .out2_no(out2_no), .tx_bit_i(tx_bit_i), .sout_o(sout_o),
    .sin_i(sin_i), .rx_bit_o(rx_bit_o), .irq_raw_i(irq_raw_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wr_data_i = ~v;
  endtask

  // all outputs against values derived from the requirements
  task automatic sweep(input logic [7:0] w);
    logic lp;
    lp = w[4];
    for (int k = 0; k < 128; k++) begin
      {irq_raw_i, sin_i, tx_bit_i, dcd_ni, ri_ni, dsr_ni, cts_ni} = k[6:0];
      #0.2;
      chk("R2", rd_data_o, {3'b000, w[4:0]});
      if (!lp) begin
        chk("R3", {7'd0, rts_no}, {7'd0, ~w[1]});
        chk("R4", {7'd0, dtr_no}, {7'd0, ~w[0]});
        chk("R5", {6'd0, out2_no, out1_no}, {6'd0, ~w[3], ~w[2]});
        chk("R8", {6'd0, sout_o, rx_bit_o}, {6'd0, tx_bit_i, sin_i});
        chk("R9", {4'd0, msr_stat_o}, {4'd0, ~dcd_ni, ~ri_ni, ~dsr_ni, ~cts_ni});
      end else begin
        chk("R7", {4'd0, out2_no, out1_no, rts_no, dtr_no}, 8'h0f);
        chk("R8", {6'd0, sout_o, rx_bit_o}, {6'd0, 1'b1, tx_bit_i});
        chk("R9", {4'd0, msr_stat_o}, {4'd0, w[3], w[2], w[0], w[1]});
      end
      chk("R6", {7'd0, irq_o}, {7'd0, irq_raw_i & w[3]});
    end
  endtask

  initial begin
    #12;
    chk("R1", rd_data_o, 8'h00);
    chk("R1", {4'd0, out2_no, out1_no, rts_no, dtr_no}, 8'h0f);
    rst_ni = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      sweep(v[7:0]);
      // R2 hold: a few idle edges must not change the value
      repeat (2) @(negedge clk_i);
      chk("R2", rd_data_o, {3'b000, v[4:0]});
    end
    wr(8'h1f);
    #1 rst_ni = 1'b0;
    #1;
    chk("R1", rd_data_o, 8'h00);
    chk("R1", {4'd0, out2_no, out1_no, rts_no, dtr_no}, 8'h0f);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk_i);
      cycles++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule